// File: doc/BRIEF.md
# Programmable Square-Wave Clock Output Timer

This block turns a general-purpose up-counting timer into a programmable clock source. Once the mode is selected and the timer is running, the oscillator clock passes through a selectable prescaler and a fixed divide-by-two stage. The result is a stream of count ticks. On each tick the counter advances by one. When it wraps past all-ones, it reloads from a software-written reload register on that same edge, and the output pin flips its level. The high and low phases of the pin are therefore always equal in length, so the duty cycle is 50%. The frequency is set by the reload value and the prescale choice.

An overflow in this mode does only two things: it reloads the counter and toggles the pin. It raises no interrupt, so the same timer can also pace a serial baud clock. The mode needs the output enable set, the internal clock source chosen and the auto-reload behaviour chosen, all at the same time. If any of these is missing, the pin sits at its idle level of 1.

The prescale divisor is P. With a counter of width W and a reload value R, the output period is 4·P·(2^W − R) oscillator cycles. The factor four comes from the divide-by-two stage together with the two halves of each output period.

Top module: `clkout_gen`

## Requirements
- R1: The mode is selected only when `out_en`=1, `ext_cnt_sel`=0 and `capture_sel`=0. While it is not selected, the counter does not advance, whatever `run` is.
- R2: In any cycle in which the mode is not selected, `clk_out` is 1 from the next clock edge on.
- R3: While the mode is selected and `run`=0, `clk_out` and `count` both hold their values.
- R4: An overflow loads `reload` into the counter on the same edge that toggles `clk_out`. Right after a toggle, `count` equals the reload value.
- R5: `clk_out` changes only on an overflow. Consecutive high and low phases have equal length, giving a 50% duty cycle.
- R6: `pre_sel` picks the prescale divisor P: 2'b00 gives DIV_FINE (4), 2'b01 gives DIV_MID (64), and 2'b10 or 2'b11 gives DIV_COARSE (1024). A further divide-by-two follows, so there is one count tick every 2·P clocks.
- R7: On each count tick the counter increments by exactly one. It overflows on the tick that finds it at all-ones.
- R8: Each phase of `clk_out` lasts 2·P·(2^W − R) clocks, so the full period is 4·P·(2^W − R). R = all-ones gives the fastest output, at 4·P clocks.
- R9: After reset, `clk_out` is 1 and `count` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pre_sel | input | 2 | Prescale divisor select |
| out_en | input | 1 | Clock-output enable bit |
| ext_cnt_sel | input | 1 | Counter/timer select, 0 = internal clock |
| capture_sel | input | 1 | Capture/reload select, 0 = auto-reload |
| run | input | 1 | Run control |
| reload | input | CNT_W | Reload value (high and low bytes together) |
| clk_out | output | 1 | Square-wave output pin |
| count | output | CNT_W | Current counter value |

## Verification
The bench builds the block with CNT_W = 8 and leaves the three prescale divisors at their defaults of 4, 64 and 1024. The narrow counter makes the first wrap after reset arrive within about two thousand clocks, rather than half a million. That puts the coarsest divisor, several reload values and repeated phase measurements all within a short run. Keeping the real divisors means every measured phase length can be compared directly against the period formula for each prescale setting.

// File: rtl/clkout_pkg.sv
package clkout_pkg;

    typedef enum logic [1:0] {
        PSEL_FINE   = 2'b00,
        PSEL_MID    = 2'b01,
        PSEL_COARSE = 2'b10,
        PSEL_ALT    = 2'b11
    } psel_e;

endpackage

// File: rtl/clkout_prescaler.sv
module clkout_prescaler
    import clkout_pkg::*;
#(
    parameter int DIV_FINE   = 4,
    parameter int DIV_MID    = 64,
    parameter int DIV_COARSE = 1024
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clear,
    input  logic  enable,
    input  psel_e sel,
    output logic  tick
);
    localparam int PW = $clog2(DIV_COARSE + 1);
    localparam logic [PW-1:0] LAST_FINE   = PW'(DIV_FINE - 1);
    localparam logic [PW-1:0] LAST_MID    = PW'(DIV_MID - 1);
    localparam logic [PW-1:0] LAST_COARSE = PW'(DIV_COARSE - 1);

    typedef struct packed {
        logic [PW-1:0] pre;
        logic          half;
    } pre_state_t;

    pre_state_t st_d, st_q;
    logic [PW-1:0] last;
    logic          wrap;

    always_comb begin
        unique case (sel)
            PSEL_FINE: last = LAST_FINE;
            PSEL_MID:  last = LAST_MID;
            default:   last = LAST_COARSE;
        endcase
        wrap = (st_q.pre >= last);
        tick = enable && wrap && st_q.half;
        st_d = st_q;
        if (clear) begin
            st_d = '0;
        end else if (enable) begin
            if (wrap) begin
                st_d.pre  = '0;
                st_d.half = ~st_q.half;
            end else begin
                st_d.pre = st_q.pre + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_TICK_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick); // R6
    AST_NO_TICK_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !tick); // R1

endmodule

// File: rtl/clkout_counter.sv
module clkout_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [CNT_W-1:0] reload,
    output logic             ovf,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] ALL_ONES = '1;

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t st_d, st_q;

    always_comb begin
        ovf  = tick && (st_q.cnt == ALL_ONES);
        st_d = st_q;
        if (tick) begin
            if (ovf) st_d.cnt = reload;
            else     st_d.cnt = st_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt = st_q.cnt;

    AST_RELOAD_ON_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        ovf |=> cnt == $past(reload)); // R4
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !ovf) |=> cnt == $past(cnt) + 1'b1); // R7
    AST_NO_TICK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(cnt)); // R3

endmodule

// File: rtl/clkout_toggle.sv
module clkout_toggle (
    input  logic clk,
    input  logic rst_n,
    input  logic mode,
    input  logic ovf,
    output logic pin
);
    typedef struct packed {
        logic pin;
    } pin_state_t;

    pin_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (!mode)    st_d.pin = 1'b1;
        else if (ovf) st_d.pin = ~st_q.pin;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{pin: 1'b1};
        else        st_q <= st_d;
    end

    assign pin = st_q.pin;

    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !mode |=> pin); // R2
    AST_TOGGLE_ONLY_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && !ovf) |=> $stable(pin)); // R5
    AST_FLIP_ON_OVF: assert property (@(posedge clk) disable iff (!rst_n)
        (mode && ovf) |=> pin != $past(pin)); // R4

endmodule

// File: rtl/clkout_gen.sv
module clkout_gen
    import clkout_pkg::*;
#(
    parameter int CNT_W      = 16,
    parameter int DIV_FINE   = 4,
    parameter int DIV_MID    = 64,
    parameter int DIV_COARSE = 1024
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       pre_sel,
    input  logic             out_en,
    input  logic             ext_cnt_sel,
    input  logic             capture_sel,
    input  logic             run,
    input  logic [CNT_W-1:0] reload,
    output logic             clk_out,
    output logic [CNT_W-1:0] count
);
    logic mode_sel;
    logic active;
    logic tick;
    logic ovf;

    always_comb begin
        mode_sel = out_en && !ext_cnt_sel && !capture_sel;
        active   = mode_sel && run;
    end

    clkout_prescaler #(
        .DIV_FINE   (DIV_FINE),
        .DIV_MID    (DIV_MID),
        .DIV_COARSE (DIV_COARSE)
    ) u_pre (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (!mode_sel),
        .enable (active),
        .sel    (psel_e'(pre_sel)),
        .tick   (tick)
    );

    clkout_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick),
        .reload (reload),
        .ovf    (ovf),
        .cnt    (count)
    );

    clkout_toggle u_tgl (
        .clk   (clk),
        .rst_n (rst_n),
        .mode  (mode_sel),
        .ovf   (ovf),
        .pin   (clk_out)
    );

    AST_STOPPED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_sel && !run) |=> ($stable(clk_out) && $stable(count))); // R3
    AST_DESELECT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_sel |=> $stable(count)); // R1

endmodule

// File: tb/clkout_gen_tb.sv
module clkout_gen_tb;
    localparam int W = 8;
    localparam int SYNC_LIMIT = 20000;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [1:0]   pre_sel = 2'b00;
    logic         out_en = 1'b0;
    logic         ext_cnt_sel = 1'b0;
    logic         capture_sel = 1'b0;
    logic         run = 1'b0;
    logic [W-1:0] reload = '0;
    logic         clk_out;
    logic [W-1:0] count;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    clkout_gen #(.CNT_W(W)) u_dut (
        .clk         (clk),
        .rst_n       (rst_n),
        .pre_sel     (pre_sel),
        .out_en      (out_en),
        .ext_cnt_sel (ext_cnt_sel),
        .capture_sel (capture_sel),
        .run         (run),
        .reload      (reload),
        .clk_out     (clk_out),
        .count       (count)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // wait for the next level change of clk_out; returns the clocks elapsed
    task automatic wait_flip(output int n);
        logic prev;
        prev = clk_out;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (clk_out == prev && n < SYNC_LIMIT);
    endtask

    task automatic measure(input int pdiv, input int r, input string tag);
        int n;
        int h;
        h = 2 * pdiv * ((1 << W) - r);
        wait_flip(n);
        wait_flip(n);
        chk(count == r[W-1:0], {tag, " R4 reload on flip"}, int'(count), r);
        wait_flip(n);
        chk(n == h, {tag, " R8 phase A"}, n, h);
        wait_flip(n);
        chk(n == h, {tag, " R5 phase B equal"}, n, h);
    endtask

    task automatic t_reset();
        chk(clk_out == 1'b1, "R9 clk_out after reset", int'(clk_out), 1);
        chk(count == '0, "R9 count after reset", int'(count), 0);
    endtask

    task automatic t_gate(input bit oe, input bit ct, input bit cp);
        @(negedge clk);
        out_en = oe; ext_cnt_sel = ct; capture_sel = cp; run = 1'b1;
        repeat (60) @(negedge clk);
        chk(count == '0, "R1 no count when deselected", int'(count), 0);
        chk(clk_out == 1'b1, "R2 idle level when deselected", int'(clk_out), 1);
    endtask

    task automatic t_fastest();
        @(negedge clk);
        pre_sel = 2'b00; reload = 8'hFF;
        out_en = 1'b1; ext_cnt_sel = 1'b0; capture_sel = 1'b0; run = 1'b1;
        measure(4, 255, "fine/FF");
    endtask

    task automatic t_step();
        int n;
        @(negedge clk);
        reload = 8'hF0;
        wait_flip(n);
        wait_flip(n);
        chk(count == 8'hF0, "R4 reload F0", int'(count), 'hF0);
        repeat (7) @(negedge clk);
        chk(count == 8'hF0, "R7 no step before 2P clocks", int'(count), 'hF0);
        @(negedge clk);
        chk(count == 8'hF1, "R7 step after 2P clocks", int'(count), 'hF1);
        measure(4, 'hF0, "fine/F0");
    endtask

    task automatic t_presc(input logic [1:0] s, input int pdiv, input int r, input string tag);
        @(negedge clk);
        pre_sel = s; reload = r[W-1:0];
        measure(pdiv, r, {tag, " R6"});
    endtask

    task automatic t_stop();
        logic [W-1:0] c0;
        logic o0;
        bit ok;
        @(negedge clk);
        run = 1'b0;
        @(negedge clk);
        c0 = count; o0 = clk_out; ok = 1'b1;
        repeat (300) begin
            @(negedge clk);
            if (count != c0 || clk_out != o0) ok = 1'b0;
        end
        chk(ok && count == c0, "R3 count holds while stopped", int'(count), int'(c0));
        chk(clk_out == o0, "R3 clk_out holds while stopped", int'(clk_out), int'(o0));
        run = 1'b1;
    endtask

    task automatic t_idle();
        int n;
        @(negedge clk);
        pre_sel = 2'b00; reload = 8'hFF;
        wait_flip(n);
        if (clk_out == 1'b1) wait_flip(n);
        chk(clk_out == 1'b0, "R5 pin low before deselect", int'(clk_out), 0);
        out_en = 1'b0;
        @(negedge clk);
        chk(clk_out == 1'b1, "R2 pin idles high next edge", int'(clk_out), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_gate(1'b0, 1'b0, 1'b0);
        t_gate(1'b1, 1'b1, 1'b0);
        t_gate(1'b1, 1'b0, 1'b1);
        t_fastest();
        t_step();
        t_presc(2'b01, 64, 'hFE, "mid/FE");
        t_presc(2'b10, 1024, 'hFF, "coarse/FF");
        t_presc(2'b11, 1024, 'hFF, "alt/FF");
        t_stop();
        t_idle();
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (180000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule